// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single DMA channel that walks a chain of five-word descriptors kept in page 0 of memory. Each descriptor holds, from its head address upward, a configuration word, a start page, a start address, a word count and a pointer to the next descriptor. The channel reads the configuration word first. It loads the remaining four words only when the ownership flag shows that software has released the descriptor. It then moves the requested number of words between memory and a byte-wide peripheral, using a request/acknowledge handshake.

When a descriptor is done, the channel writes a status word back to the descriptor head and clears the ownership flag there, so the descriptor returns to software. It then follows the next pointer. A chain ends when the next descriptor's configuration word is zero, or when that descriptor is owned but not enabled. In either case the channel clears its own enable. Software drives the channel through four write-only registers and receives one interrupt line.

Top module: `dma_desc_chan`

## Requirements
- R1: Register map on `reg_addr`: 0 = control (bit 0 is the channel enable), 1 = next-descriptor pointer, 2 = descriptor-ready strobe (a write of any value), 3 = interrupt clear. Setting the enable while the channel is idle starts a fetch of the configuration word at page 0, at the address held in the next-descriptor pointer.
- R2: Configuration word fields: bit 15 = ownership, bit 0 = descriptor enable, bit 1 = direction (1 = memory to peripheral, 0 = peripheral to memory), bit 2 = interrupt on completion. When ownership is 1 and the descriptor enable is 1, the channel loads HEAD+1 to HEAD+4 as page, address, count and next pointer, then transfers.
- R3: When the configuration word is non-zero and its ownership bit is 0, the channel waits. It makes no transfer and no write-back until a descriptor-ready write, after which it reads the configuration word again.
- R4: In memory-to-peripheral mode, each acknowledge presents the low byte of the memory word at {page, address} on `per_wdata`. After each acknowledge the address increases by 1 and the count decreases by 1, until the count reaches zero.
- R5: In peripheral-to-memory mode, each acknowledged `per_rdata` byte is written, zero-extended, to consecutive words starting at {page, address}.
- R6: When the count reaches zero, HEAD+0 is rewritten as the configuration word with bit 15 cleared and bit 3 (done) set. The channel then fetches the descriptor that the loaded next pointer names.
- R7: A completed descriptor with bit 2 set raises `irq`. The line stays high until the value 0x0001 is written to register 3; a write of any other value leaves it set.
- R8: A configuration word equal to 0x0000 clears the channel enable. The channel stops with no write-back and no transfer.
- R9: A configuration word whose ownership bit is 1 and whose descriptor-enable bit is 0 also clears the channel enable and stops the channel, leaving memory unchanged.
- R10: Writing 0 to the control enable aborts a running descriptor: no further acknowledges, no write-back and no interrupt follow.
- R11: A descriptor whose count is zero makes no transfer and goes straight to write-back.
- R12: `mem_rd` and `mem_wr` are never high together, and `per_ack` is high only while `per_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| mem_rd | output | 1 | Memory read; data arrives on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Memory write |
| mem_addr | output | PG_W+16 | Memory word address {page, offset} |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| per_req | input | 1 | Peripheral ready for one byte |
| per_ack | output | 1 | One byte transferred this cycle |
| per_wdata | output | 8 | Byte sent to the peripheral |
| per_rdata | input | 8 | Byte received from the peripheral |
| irq | output | 1 | Completion interrupt, pending until cleared |

## Verification
A wrong field latch or a wrong address step shows at the ports within one transfer. Either the wrong byte appears on `per_wdata`, or a write lands at an unexpected memory address, and the bench's byte log and memory model catch it at once. A broken ownership or stop decision shows within a few cycles of the configuration fetch. It appears as acknowledges that should not occur, or as a head word that changes when it should stay, or stays when it should change. Interrupt or abort faults show on `irq`, or as acknowledges that continue during the idle window the bench observes after each operation.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
    localparam int DW       = 16;
    localparam int BW       = 8;
    localparam int OWN_BIT  = 15;
    localparam int DEN_BIT  = 0;
    localparam int DIR_BIT  = 1;
    localparam int IRQ_BIT  = 2;
    localparam int DONE_BIT = 3;
    localparam int DESC_WORDS = 5;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_NEXT  = 2'd1,
        RA_READY = 2'd2,
        RA_ICLR  = 2'd3
    } reg_sel_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD, ST_CAP, ST_WOWN, ST_XFER,
        ST_TXRD, ST_TXCAP, ST_PWAIT, ST_RXWR, ST_WB
    } eng_st_e;

    typedef struct packed {
        logic [DW-1:0] cfg;
        logic [DW-1:0] page;
        logic [DW-1:0] addr;
        logic [DW-1:0] cnt;
        logic [DW-1:0] next;
    } desc_t;

    function automatic logic [DW-1:0] status_word(input logic [DW-1:0] cfg);
        logic [DW-1:0] w;
        w = cfg;
        w[OWN_BIT]  = 1'b0;
        w[DONE_BIT] = 1'b1;
        return w;
    endfunction

    function automatic logic ends_chain(input logic [DW-1:0] cfg);
        return (cfg == '0) || (cfg[OWN_BIT] && !cfg[DEN_BIT]);
    endfunction
endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          en_clr,
    input  logic          irq_set,
    output logic          en,
    output logic [DW-1:0] nptr,
    output logic          ready,
    output logic          irq
);
    logic clr_hit;
    assign clr_hit = reg_we && (reg_addr == RA_ICLR) && (reg_wdata == 16'h0001);
    assign ready   = reg_we && (reg_addr == RA_READY);

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= 1'b0;
            nptr <= '0;
            irq  <= 1'b0;
        end else begin
            if (en_clr)
                en <= 1'b0;
            else if (reg_we && reg_addr == RA_CTRL)
                en <= reg_wdata[0];
            if (reg_we && reg_addr == RA_NEXT)
                nptr <= reg_wdata;
            if (irq_set)
                irq <= 1'b1;
            else if (clr_hit)
                irq <= 1'b0;
        end
    end

    // R7: pending interrupt drops only after the exact clear value
    a_r7_irq_clear_only: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(reg_we && reg_addr == RA_ICLR && reg_wdata == 16'h0001));
endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
    import dmach_pkg::*;
#(
    parameter int PG_W = 8,
    localparam int MA_W = PG_W + DW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [DW-1:0]   nptr,
    input  logic            ready,
    output logic            en_clr,
    output logic            irq_set,
    output logic            busy,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [MA_W-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            per_req,
    output logic            per_ack,
    output logic [BW-1:0]   per_wdata,
    input  logic [BW-1:0]   per_rdata
);
    eng_st_e       st;
    logic [2:0]    fidx;
    logic [DW-1:0] head;
    desc_t         d;
    logic [BW-1:0] dbuf;

    logic [MA_W-1:0] desc_addr, data_addr;
    assign desc_addr = {{PG_W{1'b0}}, head + DW'(fidx)};
    assign data_addr = {d.page[PG_W-1:0], d.addr};

    always_comb begin
        mem_rd    = en && (st == ST_RD || st == ST_TXRD);
        mem_wr    = en && (st == ST_RXWR || st == ST_WB);
        mem_addr  = (st == ST_RD) ? desc_addr :
                    (st == ST_WB) ? {{PG_W{1'b0}}, head} : data_addr;
        mem_wdata = (st == ST_WB) ? status_word(d.cfg) : {{(DW-BW){1'b0}}, dbuf};
        per_ack   = en && (st == ST_PWAIT) && per_req;
        per_wdata = dbuf;
        en_clr    = en && (st == ST_CAP) && (fidx == 3'd0) && ends_chain(mem_rdata);
        irq_set   = en && (st == ST_WB) && d.cfg[IRQ_BIT];
        busy      = (st != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            fidx <= '0;
            head <= '0;
            d    <= '0;
            dbuf <= '0;
        end else if (!en) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    head <= nptr;
                    fidx <= '0;
                    st   <= ST_RD;
                end
                ST_RD: st <= ST_CAP;
                ST_CAP: begin
                    if (fidx == 3'd0) begin
                        d.cfg <= mem_rdata;
                        if (ends_chain(mem_rdata))
                            st <= ST_IDLE;
                        else if (mem_rdata[OWN_BIT]) begin
                            fidx <= 3'd1;
                            st   <= ST_RD;
                        end else
                            st <= ST_WOWN;
                    end else begin
                        case (fidx)
                            3'd1:    d.page <= mem_rdata;
                            3'd2:    d.addr <= mem_rdata;
                            3'd3:    d.cnt  <= mem_rdata;
                            default: d.next <= mem_rdata;
                        endcase
                        if (fidx == 3'(DESC_WORDS - 1))
                            st <= ST_XFER;
                        else begin
                            fidx <= fidx + 3'd1;
                            st   <= ST_RD;
                        end
                    end
                end
                ST_WOWN: if (ready) begin
                    fidx <= '0;
                    st   <= ST_RD;
                end
                ST_XFER: begin
                    if (d.cnt == '0)           st <= ST_WB;
                    else if (d.cfg[DIR_BIT])   st <= ST_TXRD;
                    else                       st <= ST_PWAIT;
                end
                ST_TXRD: st <= ST_TXCAP;
                ST_TXCAP: begin
                    dbuf <= mem_rdata[BW-1:0];
                    st   <= ST_PWAIT;
                end
                ST_PWAIT: if (per_req) begin
                    if (d.cfg[DIR_BIT]) begin
                        d.cnt  <= d.cnt - 1'b1;
                        d.addr <= d.addr + 1'b1;
                        st     <= ST_XFER;
                    end else begin
                        dbuf <= per_rdata;
                        st   <= ST_RXWR;
                    end
                end
                ST_RXWR: begin
                    d.cnt  <= d.cnt - 1'b1;
                    d.addr <= d.addr + 1'b1;
                    st     <= ST_XFER;
                end
                ST_WB: begin
                    head <= d.next;
                    fidx <= '0;
                    st   <= ST_RD;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R12: one memory access per cycle, acknowledge only on request
    a_r12_single_access: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    a_r12_ack_on_req: assert property (@(posedge clk) disable iff (rst)
        per_ack |-> per_req);
    // R3: a waiting channel leaves the wait only through a ready strobe or disable
    a_r3_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WOWN && en && !ready) |=> (st == ST_WOWN));
endmodule

// File: rtl/dma_desc_chan.sv
module dma_desc_chan
    import dmach_pkg::*;
#(
    parameter int PG_W = 8,
    localparam int MA_W = PG_W + DW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [1:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [MA_W-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            per_req,
    output logic            per_ack,
    output logic [BW-1:0]   per_wdata,
    input  logic [BW-1:0]   per_rdata,
    output logic            irq
);
    logic          en, en_clr, irq_set, ready, busy;
    logic [DW-1:0] nptr;

    dmach_regs u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .en_clr(en_clr), .irq_set(irq_set),
        .en(en), .nptr(nptr), .ready(ready), .irq(irq)
    );

    dmach_engine #(.PG_W(PG_W)) u_eng (
        .clk(clk), .rst(rst), .en(en), .nptr(nptr), .ready(ready),
        .en_clr(en_clr), .irq_set(irq_set), .busy(busy),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .per_req(per_req), .per_ack(per_ack), .per_wdata(per_wdata),
        .per_rdata(per_rdata)
    );

    // R10: a dropped enable leaves the engine idle on the next cycle
    a_r10_abort_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(en) |=> !busy);
    // R7: an interrupt rises only out of an active descriptor
    a_r7_irq_from_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(busy));
endmodule

// File: tb/dma_desc_chan_test.sv
module dma_desc_chan_test;
    localparam int CLK_P = 10;
    localparam int PG_W  = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic mem_rd, mem_wr;
    logic [PG_W+15:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic per_req = 1'b0, per_ack;
    logic [7:0] per_wdata, per_rdata = '0;
    logic irq;

    int checks = 0, fails = 0, cyc = 0, acks = 0;
    logic [15:0] mem [0:1023];
    logic [7:0] txlog[$];
    logic [7:0] rxlog[$];

    always #(CLK_P/2) clk = ~clk;

    dma_desc_chan #(.PG_W(PG_W)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .per_req(per_req), .per_ack(per_ack), .per_wdata(per_wdata),
        .per_rdata(per_rdata), .irq(irq)
    );

    function automatic int mi(input logic [1:0] pg, input logic [7:0] a);
        return {22'd0, pg, a};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_wr) mem[mi(mem_addr[17:16], mem_addr[7:0])] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mi(mem_addr[17:16], mem_addr[7:0])];
        if (per_ack) begin
            acks <= acks + 1;
            txlog.push_back(per_wdata);
            rxlog.push_back(per_rdata);
        end
    end

    always @(negedge clk) begin
        per_req   <= ($urandom % 4) != 0;
        per_rdata <= 8'($urandom);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(input int lim);
        for (int i = 0; i < lim && !irq; i++) @(negedge clk);
    endtask

    task automatic put_desc(input logic [7:0] h, input logic [15:0] cfg, input logic [15:0] pg,
                            input logic [15:0] ad, input logic [15:0] cn, input logic [15:0] nx);
        mem[mi(0, h)]   = cfg;
        mem[mi(0, h+1)] = pg;
        mem[mi(0, h+2)] = ad;
        mem[mi(0, h+3)] = cn;
        mem[mi(0, h+4)] = nx;
    endtask

    task automatic start(input logic [15:0] h);
        txlog.delete(); rxlog.delete();
        acks = 0;
        wr(2'd1, h);
        wr(2'd0, 16'h0001);
    endtask

    function automatic logic [15:0] stat(input logic [15:0] cfg);
        return (cfg & 16'h7FFF) | 16'h0008;
    endfunction

    initial begin
        int wd_dummy;
        wd_dummy = 0;
        forever begin
            @(negedge clk);
            if (cyc > 150000) begin
                checks++; fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd7741));
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(!irq && !mem_rd && !mem_wr && !per_ack, "R12 reset", {irq, mem_rd, mem_wr, per_ack}, 0);

        // Two-descriptor transmit chain ending at a zero word (R1 R2 R4 R6 R7 R8)
        for (int i = 0; i < 8; i++) mem[mi(1, 8'h20 + 8'(i))] = 16'($urandom);
        for (int i = 0; i < 3; i++) mem[mi(1, 8'h40 + 8'(i))] = 16'($urandom);
        put_desc(8'h10, 16'h8003, 16'h1, 16'h0020, 16'd5, 16'h0018);
        put_desc(8'h18, 16'h8007, 16'h1, 16'h0040, 16'd3, 16'h0030);
        start(16'h0010);
        wait_irq(2000);
        idle(30);
        chk(acks == 8, "R4 tx count", acks, 8);
        begin
            bit ok; ok = (txlog.size() == 8);
            for (int i = 0; i < 5 && ok; i++) ok = (txlog[i] == mem[mi(1, 8'h20 + 8'(i))][7:0]);
            for (int i = 0; i < 3 && ok; i++) ok = (txlog[5+i] == mem[mi(1, 8'h40 + 8'(i))][7:0]);
            chk(ok, "R4 R2 tx bytes", txlog.size(), 8);
        end
        chk(mem[mi(0, 8'h10)] == 16'h000B, "R6 status first", mem[mi(0, 8'h10)], 16'h000B);
        chk(mem[mi(0, 8'h18)] == 16'h000F, "R6 status second", mem[mi(0, 8'h18)], 16'h000F);
        chk(irq, "R7 irq set", irq, 1);
        acks = 0; idle(50);
        chk(acks == 0 && mem[mi(0, 8'h30)] == 16'h0, "R8 stopped", acks, 0);

        // R7 interrupt clear needs exact value
        wr(2'd3, 16'h0002); idle(2);
        chk(irq, "R7 wrong clear value", irq, 1);
        wr(2'd3, 16'h0001); idle(2);
        chk(!irq, "R7 clear", irq, 0);

        // R3 ownership wait, then R5 receive
        put_desc(8'h50, 16'h0001, 16'h2, 16'h0060, 16'd4, 16'h0030);
        start(16'h0050);
        idle(40);
        chk(acks == 0 && mem[mi(0, 8'h50)] == 16'h0001, "R3 waits unowned", acks, 0);
        wr(2'd2, 16'h0000); idle(40);
        chk(acks == 0 && !irq, "R3 ready still unowned", acks, 0);
        mem[mi(0, 8'h50)] = 16'h8005;
        wr(2'd2, 16'h0000);
        wait_irq(2000); idle(20);
        chk(acks == 4, "R3 R5 rx count", acks, 4);
        begin
            bit ok; ok = (rxlog.size() == 4);
            for (int i = 0; i < 4 && ok; i++) ok = (mem[mi(2, 8'h60 + 8'(i))] == {8'h0, rxlog[i]});
            chk(ok, "R5 rx data", rxlog.size(), 4);
        end
        chk(mem[mi(0, 8'h50)] == 16'h000D, "R6 rx status", mem[mi(0, 8'h50)], 16'h000D);
        wr(2'd3, 16'h0001);

        // R10 abort
        put_desc(8'h70, 16'h8007, 16'h1, 16'h0080, 16'd40, 16'h0030);
        start(16'h0070);
        for (int i = 0; i < 3000 && acks < 6; i++) @(negedge clk);
        wr(2'd0, 16'h0000);
        acks = 0; idle(60);
        chk(acks == 0, "R10 no acks after abort", acks, 0);
        chk(mem[mi(0, 8'h70)] == 16'h8007 && !irq, "R10 no write-back", mem[mi(0, 8'h70)], 16'h8007);

        // R11 zero count
        put_desc(8'h90, 16'h8003, 16'h1, 16'h0020, 16'd0, 16'h0030);
        start(16'h0090); idle(60);
        chk(acks == 0 && mem[mi(0, 8'h90)] == 16'h000B, "R11 zero count", mem[mi(0, 8'h90)], 16'h000B);

        // R9 owned but not enabled
        put_desc(8'hA0, 16'h8002, 16'h1, 16'h0020, 16'd3, 16'h0030);
        start(16'h00A0); idle(60);
        chk(acks == 0 && mem[mi(0, 8'hA0)] == 16'h8002, "R9 owned disabled", mem[mi(0, 8'hA0)], 16'h8002);
        // channel enable was cleared: a ready strobe must not revive it
        wr(2'd2, 16'h0000); idle(30);
        chk(acks == 0, "R9 enable cleared", acks, 0);

        // random descriptors (R4 R5 R6)
        for (int r = 0; r < 8; r++) begin
            logic dir; logic [15:0] cn, cfg;
            dir = 1'($urandom);
            cn  = 16'(1 + $urandom % 8);
            cfg = 16'h8005 | {14'd0, dir, 1'b0};
            for (int i = 0; i < 8; i++) mem[mi(3, 8'h10 + 8'(i))] = 16'($urandom);
            put_desc(8'hC0, cfg, 16'h3, 16'h0010, cn, 16'h0030);
            start(16'h00C0);
            wait_irq(3000); idle(20);
            begin
                bit ok; ok = (acks == int'(cn));
                for (int i = 0; i < int'(cn) && ok; i++)
                    ok = dir ? (txlog[i] == mem[mi(3, 8'h10 + 8'(i))][7:0])
                             : (mem[mi(3, 8'h10 + 8'(i))] == {8'h0, rxlog[i]});
                chk(ok, dir ? "R4 random tx" : "R5 random rx", acks, cn);
            end
            chk(mem[mi(0, 8'hC0)] == stat(cfg), "R6 random status", mem[mi(0, 8'hC0)], stat(cfg));
            wr(2'd3, 16'h0001);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule